// File: doc/BRIEF.md
# One-Pulse Timer with Forced Compare

This block is a 16-bit timer built around a free-running up-counter. It has two capture inputs and two compare channels. Each capture input passes through a two-flop synchronizer before its edge is detected. In normal operation, the selected edge copies the counter into that channel's capture register. Each compare channel watches for the counter to equal its compare register. On a match it raises a flag and drives its programmed level onto its output.

Software can also set a compare output directly with a force action. A force raises no flag.

In one-pulse mode, a selected edge on capture input 1 reloads the counter with a fixed value near wrap. On that edge, compare output 1 switches to its pulse level. A later match on compare channel 1 drives the idle level again. Software chooses the pulse length through compare register 1 and the two levels through control bits.

Software reaches everything through a simple register port. Writes take one cycle. Reads are combinational from the read address.

Top module: `pulse_timer`

## Requirements
- R1: After reset the counter is 0. It then rises by one each clock and wraps from 0xFFFF to 0. The only exception is the one-pulse restart in R3. The counter reads at address 7.
- R2: Each capture input is synchronized by two flops. Its edge is detected one flop later, and the edge acts on state at the following clock edge.
  - The active edge is rising when the channel's edge bit is 1 and falling when it is 0.
  - On an active edge, the capture register takes the counter value of that cycle and the channel's capture flag is set.
  - Capture input 2 keeps capturing like this in one-pulse mode.
  - Capture registers 1 and 2 read at addresses 4 and 5.
- R3: In one-pulse mode (one-pulse enable set and PWM enable clear), an active edge on capture input 1 does all of the following:
  - the counter loads 0xFFFC;
  - capture register 1 loads 0xFFFD;
  - capture flag 1 is set;
  - the pin state of output 1 takes level bit 2.
  An edge during a pulse restarts it. An edge wins over a compare-1 match in the same cycle.
- R4: In one-pulse mode, a compare-1 match drives level bit 1 onto the output 1 state, and compare flag 1 is never set.
- R5: In one-pulse mode, a compare-2 match still sets compare flag 2, but the pin state of output 2 does not change.
- R6: Outside one-pulse and PWM modes, a match on channel i sets compare flag i and loads level bit i into pin state i.
- R7: Writing 1 to a force bit loads the written level bit into the pin state on the next clock edge and sets no flag. This holds only when neither the one-pulse enable nor the PWM enable is set. A force wins over a match in the same cycle.
- R8: While the PWM enable is set, both pin states hold and force bits have no effect. With the PWM enable set, the one-pulse enable is ignored, and capture input 1 captures normally.
- R9: Output i equals pin state i when output enable i is set, and is 0 otherwise.
- R10: Flags are at address 6: bit 0 capture 1, bit 1 capture 2, bit 2 compare 1, bit 3 compare 2.
  - Writing 1 to a flag bit clears it.
  - A hardware set in the same cycle wins over the clear.
  - irq is high when any capture flag is set with the capture interrupt enable, or any compare flag is set with the compare interrupt enable.
- R11: Register map:
  - Control (address 0): bit 0 level 1, bit 1 level 2, bit 2 force 1, bit 3 force 2, bit 4 output enable 1, bit 5 output enable 2, bit 6 edge 1, bit 7 edge 2, bit 8 capture interrupt enable, bit 9 compare interrupt enable. The force bits read 0.
  - Mode (address 1): bit 0 one-pulse enable, bit 1 PWM enable.
  - Compare registers 1 and 2: addresses 2 and 3.
  - Every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| cap1_in | input | 1 | Capture input 1 (pulse trigger) |
| cap2_in | input | 1 | Capture input 2 |
| cmp1_out | output | 1 | Compare output 1 |
| cmp2_out | output | 1 | Compare output 2 |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock: the restart edge on capture input 1 and the compare-1 match that ends the pulse. In that cycle the restart must win, so the pulse level stays and the counter reloads. The bench provokes this by sweeping the delay of a second trigger edge across the cycles around the end of a pulse. A flag clear against a hardware set of the same flag is provoked by random clear writes. In both cases the bench compares the output pins, irq and the read-back registers with its own model on every clock.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_MODE = 3'd1,
        REG_CMP1 = 3'd2,
        REG_CMP2 = 3'd3,
        REG_CAP1 = 3'd4,
        REG_CAP2 = 3'd5,
        REG_FLAG = 3'd6,
        REG_CNT  = 3'd7
    } reg_addr_e;

    localparam int B_LVL1  = 0;
    localparam int B_LVL2  = 1;
    localparam int B_FRC1  = 2;
    localparam int B_FRC2  = 3;
    localparam int B_OE1   = 4;
    localparam int B_OE2   = 5;
    localparam int B_EDGE1 = 6;
    localparam int B_EDGE2 = 7;
    localparam int B_CAPIE = 8;
    localparam int B_CMPIE = 9;

    localparam int B_OPM = 0;
    localparam int B_PWM = 1;

    localparam int N_FLAGS = 4;
    localparam int F_CAP1  = 0;
    localparam int F_CAP2  = 1;
    localparam int F_CMP1  = 2;
    localparam int F_CMP2  = 3;
endpackage

// File: rtl/pt_edge_det.sv
module pt_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    logic cur_w, prev_w;
    assign cur_w  = sh_q[STAGES-1];
    assign prev_w = sh_q[STAGES];
    assign edge_o = rise_sel_i ? (cur_w & ~prev_w) : (~cur_w & prev_w);
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) cnt_d = load_val_i;
        else        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [pt_pkg::ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic [pt_pkg::ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]         rd_data,
    input  logic                     cap1_in,
    input  logic                     cap2_in,
    output logic                     cmp1_out,
    output logic                     cmp2_out,
    output logic                     irq
);
    import pt_pkg::*;

    localparam int N_CH = 2;
    localparam logic [CNT_W-1:0] RELOAD_CNT = {CNT_W{1'b1}} - 3;
    localparam logic [CNT_W-1:0] RELOAD_CAP = RELOAD_CNT + 1'b1;

    typedef struct packed {
        logic             lvl1;
        logic             lvl2;
        logic             oe1;
        logic             oe2;
        logic             edge1;
        logic             edge2;
        logic             cap_ie;
        logic             cmp_ie;
        logic             opm_en;
        logic             pwm_en;
        logic [CNT_W-1:0] cmp1;
        logic [CNT_W-1:0] cmp2;
        logic [CNT_W-1:0] cap1;
        logic [CNT_W-1:0] cap2;
        logic [N_FLAGS-1:0] flags;
        logic             pin1;
        logic             pin2;
    } state_t;

    state_t st_d, st_q;

    // edge detection per capture channel
    logic [N_CH-1:0] cap_pin_w;
    logic [N_CH-1:0] cap_sel_w;
    logic [N_CH-1:0] cap_edge;

    assign cap_pin_w = {cap2_in, cap1_in};
    assign cap_sel_w = {st_q.edge2, st_q.edge1};

    for (genvar g = 0; g < N_CH; g++) begin : g_edge
        pt_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (cap_pin_w[g]),
            .rise_sel_i (cap_sel_w[g]),
            .edge_o     (cap_edge[g])
        );
    end

    // counter
    logic             opm_act;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_q;

    assign opm_act  = st_q.opm_en & ~st_q.pwm_en;
    assign cnt_load = opm_act & cap_edge[0];

    pt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (RELOAD_CNT),
        .cnt_o      (cnt_q)
    );

    // register-side decode
    logic wr_ctrl, wr_mode, wr_cmp1, wr_cmp2, wr_flag;
    logic force_ok, frc1, frc2;
    logic match1, match2;
    logic [N_FLAGS-1:0] flag_set, flag_clr;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
        wr_mode  = wr_en && (wr_addr == REG_MODE);
        wr_cmp1  = wr_en && (wr_addr == REG_CMP1);
        wr_cmp2  = wr_en && (wr_addr == REG_CMP2);
        wr_flag  = wr_en && (wr_addr == REG_FLAG);
        force_ok = ~st_q.opm_en & ~st_q.pwm_en;
        frc1     = wr_ctrl & wr_data[B_FRC1] & force_ok;
        frc2     = wr_ctrl & wr_data[B_FRC2] & force_ok;
        match1   = (cnt_q == st_q.cmp1);
        match2   = (cnt_q == st_q.cmp2);
    end

    always_comb begin
        st_d     = st_q;
        flag_set = '0;
        flag_clr = wr_flag ? wr_data[N_FLAGS-1:0] : '0;

        // capture channel 1: ordinary capture or one-pulse restart
        if (cap_edge[0]) begin
            st_d.cap1        = opm_act ? RELOAD_CAP : cnt_q;
            flag_set[F_CAP1] = 1'b1;
        end
        // capture channel 2 always captures
        if (cap_edge[1]) begin
            st_d.cap2        = cnt_q;
            flag_set[F_CAP2] = 1'b1;
        end

        if (match1 && !opm_act) flag_set[F_CMP1] = 1'b1;
        if (match2)             flag_set[F_CMP2] = 1'b1;

        st_d.flags = (st_q.flags & ~flag_clr) | flag_set;

        // output 1 pin state
        if (st_q.pwm_en) begin
            st_d.pin1 = st_q.pin1;
        end else if (opm_act) begin
            if (cap_edge[0])  st_d.pin1 = st_q.lvl2;
            else if (match1)  st_d.pin1 = st_q.lvl1;
        end else if (frc1) begin
            st_d.pin1 = wr_data[B_LVL1];
        end else if (match1) begin
            st_d.pin1 = st_q.lvl1;
        end

        // output 2 pin state
        if (st_q.pwm_en || opm_act) begin
            st_d.pin2 = st_q.pin2;
        end else if (frc2) begin
            st_d.pin2 = wr_data[B_LVL2];
        end else if (match2) begin
            st_d.pin2 = st_q.lvl2;
        end

        // register writes
        if (wr_ctrl) begin
            st_d.lvl1   = wr_data[B_LVL1];
            st_d.lvl2   = wr_data[B_LVL2];
            st_d.oe1    = wr_data[B_OE1];
            st_d.oe2    = wr_data[B_OE2];
            st_d.edge1  = wr_data[B_EDGE1];
            st_d.edge2  = wr_data[B_EDGE2];
            st_d.cap_ie = wr_data[B_CAPIE];
            st_d.cmp_ie = wr_data[B_CMPIE];
        end
        if (wr_mode) begin
            st_d.opm_en = wr_data[B_OPM];
            st_d.pwm_en = wr_data[B_PWM];
        end
        if (wr_cmp1) st_d.cmp1 = wr_data;
        if (wr_cmp2) st_d.cmp2 = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL: begin
                rd_data[B_LVL1]  = st_q.lvl1;
                rd_data[B_LVL2]  = st_q.lvl2;
                rd_data[B_OE1]   = st_q.oe1;
                rd_data[B_OE2]   = st_q.oe2;
                rd_data[B_EDGE1] = st_q.edge1;
                rd_data[B_EDGE2] = st_q.edge2;
                rd_data[B_CAPIE] = st_q.cap_ie;
                rd_data[B_CMPIE] = st_q.cmp_ie;
            end
            REG_MODE: begin
                rd_data[B_OPM] = st_q.opm_en;
                rd_data[B_PWM] = st_q.pwm_en;
            end
            REG_CMP1: rd_data = st_q.cmp1;
            REG_CMP2: rd_data = st_q.cmp2;
            REG_CAP1: rd_data = st_q.cap1;
            REG_CAP2: rd_data = st_q.cap2;
            REG_FLAG: rd_data[N_FLAGS-1:0] = st_q.flags;
            REG_CNT:  rd_data = cnt_q;
            default:  rd_data = '0;
        endcase
    end

    assign cmp1_out = st_q.oe1 & st_q.pin1;
    assign cmp2_out = st_q.oe2 & st_q.pin2;
    assign irq = (st_q.cap_ie & (st_q.flags[F_CAP1] | st_q.flags[F_CAP2])) |
                 (st_q.cmp_ie & (st_q.flags[F_CMP1] | st_q.flags[F_CMP2]));

    // assertions
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(opm_act && cap_edge[0]) |=> cnt_q == $past(cnt_q) + 1'b1); // R1

    AST_OPM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (opm_act && cap_edge[0]) |=> (cnt_q == RELOAD_CNT && st_q.cap1 == RELOAD_CAP && st_q.flags[F_CAP1])); // R3

    AST_OPM_NO_CMPF1: assert property (@(posedge clk) disable iff (!rst_n)
        (opm_act && !st_q.flags[F_CMP1]) |=> !st_q.flags[F_CMP1]); // R4

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (frc1 && !match1 && !st_q.flags[F_CMP1]) |=> !st_q.flags[F_CMP1]); // R7

    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pwm_en |=> (st_q.pin1 == $past(st_q.pin1) && st_q.pin2 == $past(st_q.pin2))); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge[1] |=> st_q.flags[F_CAP2]); // R10
endmodule

// File: tb/pulse_timer_tb.sv
`timescale 1ns/100ps
module pulse_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap1_in = 1'b0;
    logic        cap2_in = 1'b0;
    logic        cmp1_out, cmp2_out, irq;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    pulse_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .cmp1_out(cmp1_out), .cmp2_out(cmp2_out), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_cnt, m_cmp1, m_cmp2, m_cap1, m_cap2;
    logic [3:0]  m_flags;
    logic m_lvl1, m_lvl2, m_oe1, m_oe2, m_edge1, m_edge2, m_capie, m_cmpie, m_opm, m_pwm;
    logic m_pin1, m_pin2;
    bit   h1[$];
    bit   h2[$];

    function automatic logic [15:0] m_read(int a);
        logic [15:0] v = '0;
        case (a)
            0: begin
                v[0] = m_lvl1; v[1] = m_lvl2; v[4] = m_oe1; v[5] = m_oe2;
                v[6] = m_edge1; v[7] = m_edge2; v[8] = m_capie; v[9] = m_cmpie;
            end
            1: begin v[0] = m_opm; v[1] = m_pwm; end
            2: v = m_cmp1;
            3: v = m_cmp2;
            4: v = m_cap1;
            5: v = m_cap2;
            6: v[3:0] = m_flags;
            default: v = m_cnt;
        endcase
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp1 = 0; m_cmp2 = 0; m_cap1 = 0; m_cap2 = 0; m_flags = 0;
            {m_lvl1, m_lvl2, m_oe1, m_oe2, m_edge1, m_edge2, m_capie, m_cmpie, m_opm, m_pwm} = '0;
            m_pin1 = 0; m_pin2 = 0;
            h1 = {0, 0, 0};
            h2 = {0, 0, 0};
        end else begin
            bit e1, e2, opm_a, f_ok, mt1, mt2;
            logic [15:0] n_cnt, n_cap1, n_cap2;
            logic [3:0] setv, clrv;
            logic n_pin1, n_pin2;
            e1 = m_edge1 ? (h1[1] && !h1[2]) : (!h1[1] && h1[2]);
            e2 = m_edge2 ? (h2[1] && !h2[2]) : (!h2[1] && h2[2]);
            opm_a = m_opm && !m_pwm;
            f_ok = !m_opm && !m_pwm;
            mt1 = (m_cnt == m_cmp1);
            mt2 = (m_cnt == m_cmp2);
            n_cnt = (opm_a && e1) ? 16'hFFFC : m_cnt + 16'd1;
            n_cap1 = m_cap1; n_cap2 = m_cap2; setv = 0;
            if (e1) begin n_cap1 = opm_a ? 16'hFFFD : m_cnt; setv[0] = 1; end
            if (e2) begin n_cap2 = m_cnt; setv[1] = 1; end
            if (mt1 && !opm_a) setv[2] = 1;
            if (mt2) setv[3] = 1;
            clrv = (wr_en && wr_addr == 6) ? wr_data[3:0] : 4'h0;
            n_pin1 = m_pin1; n_pin2 = m_pin2;
            if (!m_pwm) begin
                if (opm_a) begin
                    if (e1) n_pin1 = m_lvl2;
                    else if (mt1) n_pin1 = m_lvl1;
                end else begin
                    if (wr_en && wr_addr == 0 && wr_data[2] && f_ok) n_pin1 = wr_data[0];
                    else if (mt1) n_pin1 = m_lvl1;
                    if (wr_en && wr_addr == 0 && wr_data[3] && f_ok) n_pin2 = wr_data[1];
                    else if (mt2) n_pin2 = m_lvl2;
                end
            end
            m_flags = (m_flags & ~clrv) | setv;
            m_cnt = n_cnt; m_cap1 = n_cap1; m_cap2 = n_cap2;
            m_pin1 = n_pin1; m_pin2 = n_pin2;
            if (wr_en) begin
                case (wr_addr)
                    0: begin
                        m_lvl1 = wr_data[0]; m_lvl2 = wr_data[1]; m_oe1 = wr_data[4]; m_oe2 = wr_data[5];
                        m_edge1 = wr_data[6]; m_edge2 = wr_data[7]; m_capie = wr_data[8]; m_cmpie = wr_data[9];
                    end
                    1: begin m_opm = wr_data[0]; m_pwm = wr_data[1]; end
                    2: m_cmp1 = wr_data;
                    3: m_cmp2 = wr_data;
                    default: ;
                endcase
            end
            h1.push_front(cap1_in); void'(h1.pop_back());
            h2.push_front(cap2_in); void'(h2.pop_back());
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            string t1, tr;
            logic exp_irq;
            t1 = m_pwm ? "R8" : ((m_opm) ? "R4" : "R6");
            chk(t1, "cmp1_out", {15'b0, cmp1_out}, {15'b0, m_oe1 & m_pin1});
            chk("R5", "cmp2_out", {15'b0, cmp2_out}, {15'b0, m_oe2 & m_pin2});
            exp_irq = (m_capie && (m_flags[0] || m_flags[1])) || (m_cmpie && (m_flags[2] || m_flags[3]));
            chk("R10", "irq", {15'b0, irq}, {15'b0, exp_irq});
            case (rd_addr)
                3'd4, 3'd5: tr = "R2";
                3'd6:       tr = "R10";
                3'd7:       tr = "R1";
                default:    tr = "R11";
            endcase
            chk(tr, "rd_data", rd_data, m_read(int'(rd_addr)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk); #1;
            rd_addr = rd_addr + 3'd1;
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, logic [15:0] exp);
        rd_addr = 3'(a);
        #0.2;
        chk(req, "read", rd_data, exp);
    endtask

    localparam logic [15:0] CTRL_BASE = 16'h0330; // oe1, oe2, cap_ie, cmp_ie

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R11 reset values, R1 counter start
        rd_chk("R11", 0, 16'h0000);
        rd_chk("R11", 6, 16'h0000);
        rd_chk("R1", 7, 16'h0000);
        idle(5);
        rd_chk("R1", 7, 16'd5);

        // R6 normal compare, R2 capture
        wr(0, CTRL_BASE | 16'h0041);            // lvl1=1, lvl2=0, edge1 rising, edge2 falling
        wr(2, m_cnt + 16'd10);
        wr(3, m_cnt + 16'd18);
        idle(25);
        chk("R6", "cmp1_out after match", {15'b0, cmp1_out}, 16'd1);
        cap1_in = 1'b1; idle(2);
        cap2_in = 1'b1; idle(3);
        cap2_in = 1'b0; idle(6);
        rd_chk("R2", 6, 16'h000F);

        // R10 clear
        wr(6, 16'h000F);
        rd_chk("R10", 6, 16'h0000);
        chk("R10", "irq after clear", {15'b0, irq}, 16'd0);

        // R7 force without flag
        wr(0, CTRL_BASE | 16'h0044);             // force 1 with level 0
        rd_chk("R7", 6, 16'h0000);
        chk("R7", "forced pin", {15'b0, cmp1_out}, 16'd0);
        wr(0, CTRL_BASE | 16'h0045);             // force 1 with level 1
        chk("R7", "forced pin high", {15'b0, cmp1_out}, 16'd1);
        rd_chk("R11", 0, CTRL_BASE | 16'h0041);  // force bits read 0

        // R9 output enable
        wr(0, 16'h0321);
        chk("R9", "oe1 clear", {15'b0, cmp1_out}, 16'd0);
        wr(0, CTRL_BASE | 16'h0041);
        chk("R9", "oe1 set", {15'b0, cmp1_out}, 16'd1);

        // one-pulse mode: lvl1=0 idle, lvl2=1 pulse, edge1 rising
        cap1_in = 1'b0;
        wr(0, CTRL_BASE | 16'h0042);
        wr(2, 16'h0008);
        wr(3, 16'h0004);
        wr(1, 16'h0001);
        idle(4);
        wr(6, 16'h000F);
        cap1_in = 1'b1; idle(5);
        rd_chk("R3", 4, 16'hFFFD);
        chk("R3", "pulse level", {15'b0, cmp1_out}, 16'd1);
        idle(15);
        chk("R4", "pulse end level", {15'b0, cmp1_out}, 16'd0);
        rd_chk("R4", 6, 16'h0009);               // capf1 + cmpf2, never cmpf1
        rd_chk("R5", 3, 16'h0004);
        // force ignored in one-pulse mode
        wr(0, CTRL_BASE | 16'h0047);
        chk("R7", "force ignored in one-pulse", {15'b0, cmp1_out}, 16'd0);
        wr(0, CTRL_BASE | 16'h0042);

        // sweep a restart edge across the end of the pulse (R3 vs R4)
        for (int d = 6; d < 18; d++) begin
            cap1_in = 1'b0; idle(3);
            cap1_in = 1'b1; idle(3);
            cap1_in = 1'b0; idle(d);
            cap1_in = 1'b1; idle(20);
        end

        // R8 PWM overrides one-pulse
        wr(1, 16'h0003);
        cap1_in = 1'b0; idle(4);
        wr(6, 16'h000F);
        cap1_in = 1'b1; idle(5);
        rd_chk("R8", 6, 16'h0001);
        wr(0, CTRL_BASE | 16'h0047);
        chk("R8", "force ignored in PWM", {15'b0, cmp1_out}, {15'b0, m_pin1});
        idle(40);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 6) cap1_in = ~cap1_in;
            else if (r < 10) cap2_in = ~cap2_in;
            if (r == 20) wr(0, 16'($urandom) & 16'h03FF);
            else if (r == 21) wr(1, 16'($urandom % 4));
            else if (r == 22 || r == 23) wr(6, 16'($urandom % 16));
            else if (r == 24) wr(2, m_cnt + 16'($urandom % 30));
            else if (r == 25) wr(3, m_cnt + 16'($urandom % 30));
            else idle(1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule